// File: doc/BRIEF.md
# Character Display Controller Register Core

This block is the register side of a character display controller as a host sees it across a parallel bus. The host drives a register-select line, a read/write line, an 8-bit bus and an enable strobe. Each transfer takes effect when the strobe falls.

Selecting the control side with a write loads an address instruction. Two codes are decoded. One points the address counter into an 80-byte display RAM. The other points it into a 64-byte glyph RAM. Every other instruction code is dropped. Selecting the data side reads or writes the byte under the address counter. After each data access the counter steps, either up or down.

Reads are kept one step ahead. Loading an address, and every later data access, fetches the byte at the new address into the data register. A data read therefore returns that byte straight away. After each accepted operation a busy flag stays up for a fixed number of clocks. Until it drops, further strobes are refused. The host can poll the flag together with the address counter through a status read.

Top module: `chardisp_regcore`

## Requirements
- R1: After reset the address counter is 0, the display RAM is selected, the busy flag is 0, the data register is 0 and every byte of both RAMs is 0.
- R2: With rs_i=0 and rw_i=1, bus_o carries the busy flag in bit 7 and the address counter in bits 6..0. The instruction register is never visible on bus_o.
- R3: rs_i, rw_i and bus_i are taken from the last clock at which en_i was seen high. The operation executes on the first clock edge at which en_i is seen low after being high. Its results are visible right after that edge.
- R4: With rs_i=1 and rw_i=1, bus_o shows the data register. With rw_i=0, bus_o is 0.
- R5: An instruction byte 1aaaaaaa selects the display RAM and loads the counter with a, or with a-80 when a is 80 or more. An instruction byte 01cccccc selects the glyph RAM and loads the counter with c. Both codes then load the data register with the byte at the new address. Any other instruction byte has no effect and does not set busy.
- R6: A data write (rs_i=1, rw_i=0) stores the captured byte at the counter in the selected RAM. The counter then steps, and the data register is loaded with the byte at the new address.
- R7: A data read strobe (rs_i=1, rw_i=1) steps the counter and loads the data register with the byte at the new address.
- R8: When dir_dec_i is 1 at the executing edge, a step decrements the counter; otherwise it increments. With DIR_PORT_EN=0 the counter always increments.
- R9: The counter wraps within the selected RAM: 79 to 0 and 0 to 79 in the display RAM, 63 to 0 and 0 to 63 in the glyph RAM.
- R10: An accepted operation sets busy for BUSY_CYC clocks from its executing edge. A strobe that executes while busy is 1 changes nothing and does not extend busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable strobe; a transfer executes when it falls |
| rs_i | input | 1 | Register select: 0 = control/status, 1 = data |
| rw_i | input | 1 | 1 = read, 0 = write |
| bus_i | input | 8 | Host write data |
| dir_dec_i | input | 1 | Step direction: 1 = decrement |
| bus_o | output | 8 | Host read data (status or data register) |

## Verification
The fall of en_i takes effect at the first clock edge that sees it low, one register behind the pin. The address counter, data register and busy flag therefore change right after that edge. Busy stays up for BUSY_CYC edges counted from it. bus_o follows rs_i and rw_i with no register in between.

The bench keeps a behavioural model that is updated on the same edge. It compares bus_o 3 ns after every rising edge. Its directed reads are made half a cycle after the executing edge, and one edge either side of the busy window's end.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
   typedef logic [7:0] cd_byte_t;
   typedef enum logic [2:0] {
      CD_OP_NONE,
      CD_OP_SET_DD,
      CD_OP_SET_CG,
      CD_OP_WRITE,
      CD_OP_READ
   } cd_op_e;
endpackage

// File: rtl/cd_strobe.sv
module cd_strobe #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          rs_i,
   input  logic          rw_i,
   input  logic [DW-1:0] dat_i,
   output logic          fire_o,
   output logic          rs_o,
   output logic          rw_o,
   output logic [DW-1:0] dat_o
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         rs_o  <= 1'b0;
         rw_o  <= 1'b0;
         dat_o <= '0;
      end else begin
         en_q <= en_i;
         if (en_i) begin
            rs_o  <= rs_i;
            rw_o  <= rw_i;
            dat_o <= dat_i;
         end
      end
   end

   assign fire_o = en_q & ~en_i;
endmodule

// File: rtl/cd_busy_timer.sv
module cd_busy_timer #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start_i)
         cnt_q <= LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cd_ram.sv
module cd_ram #(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i && (int'(waddr_i) < DEPTH)) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/cd_addr_ctr.sv
module cd_addr_ctr #(
   parameter int AW       = 7,
   parameter int DD_DEPTH = 80,
   parameter int CG_DEPTH = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_dd_i,
   input  logic          ld_cg_i,
   input  logic [AW-1:0] ld_val_i,
   input  logic          step_i,
   input  logic          dec_i,
   output logic [AW-1:0] ac_o,
   output logic          sel_o,
   output logic [AW-1:0] nxt_ac_o,
   output logic          nxt_sel_o
);
   localparam logic [AW-1:0] DD_LAST = AW'(DD_DEPTH - 1);
   localparam logic [AW-1:0] CG_LAST = AW'(CG_DEPTH - 1);
   localparam logic [AW-1:0] DD_SPAN = AW'(DD_DEPTH);

   logic [AW-1:0] ac_q, last, stepped;
   logic          sel_q;

   always_comb begin
      last = sel_q ? CG_LAST : DD_LAST;
      if (dec_i)
         stepped = (ac_q == '0) ? last : ac_q - 1'b1;
      else
         stepped = (ac_q == last) ? '0 : ac_q + 1'b1;

      nxt_sel_o = sel_q;
      nxt_ac_o  = ac_q;
      if (ld_dd_i) begin
         nxt_sel_o = 1'b0;
         nxt_ac_o  = (ld_val_i >= DD_SPAN) ? ld_val_i - DD_SPAN : ld_val_i;
      end else if (ld_cg_i) begin
         nxt_sel_o = 1'b1;
         nxt_ac_o  = ld_val_i & CG_LAST;
      end else if (step_i) begin
         nxt_ac_o  = stepped;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q  <= '0;
         sel_q <= 1'b0;
      end else begin
         ac_q  <= nxt_ac_o;
         sel_q <= nxt_sel_o;
      end
   end

   assign ac_o  = ac_q;
   assign sel_o = sel_q;
endmodule

// File: rtl/chardisp_regcore.sv
module chardisp_regcore #(
   parameter int DD_DEPTH    = 80,
   parameter int CG_DEPTH    = 64,
   parameter int BUSY_CYC    = 4,
   parameter bit DIR_PORT_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       rs_i,
   input  logic       rw_i,
   input  logic [7:0] bus_i,
   input  logic       dir_dec_i,
   output logic [7:0] bus_o
);
   import chardisp_pkg::*;

   localparam int AC_W  = 7;
   localparam int CG_AW = $clog2(CG_DEPTH);

   if (DD_DEPTH < 2 || DD_DEPTH >= (1 << AC_W) || 2 * DD_DEPTH < (1 << AC_W))
      $error("DD_DEPTH must lie in [64,127]");
   if (CG_DEPTH < 2 || (1 << CG_AW) != CG_DEPTH || CG_DEPTH > (1 << (AC_W - 1)))
      $error("CG_DEPTH must be a power of two up to 64");
   if (BUSY_CYC < 1)
      $error("BUSY_CYC must be at least 1");

   logic          fire, rs_c, rw_c, busy, accept, dec, sel, nxt_sel;
   cd_byte_t      dat_c, dr_q, dd_rd, cg_rd;
   logic [AC_W-1:0] ac, nxt_ac;
   cd_op_e        op;

   cd_strobe #(.DW(8)) u_stb (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
      .dat_i(bus_i), .fire_o(fire), .rs_o(rs_c), .rw_o(rw_c), .dat_o(dat_c)
   );

   always_comb begin
      op = CD_OP_NONE;
      if (fire && !busy) begin
         unique case ({rs_c, rw_c})
            2'b00: begin
               if (dat_c[7])              op = CD_OP_SET_DD;
               else if (dat_c[6])         op = CD_OP_SET_CG;
            end
            2'b10:                        op = CD_OP_WRITE;
            2'b11:                        op = CD_OP_READ;
            default:                      op = CD_OP_NONE;
         endcase
      end
   end

   assign accept = (op != CD_OP_NONE);

   if (DIR_PORT_EN) begin : g_dir_port
      assign dec = dir_dec_i;
   end else begin : g_dir_fixed
      logic unused_dir;
      assign unused_dir = dir_dec_i;
      assign dec = 1'b0;
   end

   cd_addr_ctr #(.AW(AC_W), .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) u_ac (
      .clk(clk), .rst_n(rst_n),
      .ld_dd_i(op == CD_OP_SET_DD), .ld_cg_i(op == CD_OP_SET_CG),
      .ld_val_i(dat_c[AC_W-1:0]),
      .step_i((op == CD_OP_WRITE) || (op == CD_OP_READ)), .dec_i(dec),
      .ac_o(ac), .sel_o(sel), .nxt_ac_o(nxt_ac), .nxt_sel_o(nxt_sel)
   );

   cd_ram #(.DEPTH(DD_DEPTH), .AW(AC_W), .DW(8)) u_dd (
      .clk(clk), .rst_n(rst_n),
      .we_i((op == CD_OP_WRITE) && !sel), .waddr_i(ac), .wdata_i(dat_c),
      .raddr_i(nxt_ac), .rdata_o(dd_rd)
   );

   cd_ram #(.DEPTH(CG_DEPTH), .AW(CG_AW), .DW(8)) u_cg (
      .clk(clk), .rst_n(rst_n),
      .we_i((op == CD_OP_WRITE) && sel), .waddr_i(ac[CG_AW-1:0]), .wdata_i(dat_c),
      .raddr_i(nxt_ac[CG_AW-1:0]), .rdata_o(cg_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dr_q <= '0;
      else if (accept)
         dr_q <= nxt_sel ? cg_rd : dd_rd;
   end

   cd_busy_timer #(.CYC(BUSY_CYC)) u_busy (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .busy_o(busy)
   );

   always_comb begin
      if (!rw_i)     bus_o = '0;
      else if (rs_i) bus_o = dr_q;
      else           bus_o = {busy, ac};
   end
endmodule

// File: rtl/chardisp_regcore_chk.sv
module chardisp_regcore_chk #(
   parameter int DD_DEPTH = 80,
   parameter int CG_DEPTH = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       fire,
   input logic       busy,
   input logic       accept,
   input logic       sel,
   input logic [6:0] ac,
   input logic [7:0] dr_q
);
   localparam logic [6:0] DD_SPAN = 7'(DD_DEPTH);
   localparam logic [6:0] CG_SPAN = 7'(CG_DEPTH);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> ($stable(ac) && $stable(sel) && $stable(dr_q))); // R3
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && busy) |=> ($stable(ac) && $stable(sel) && $stable(dr_q))); // R10
   AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy); // R10
   AST_DD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> (ac < DD_SPAN)); // R9
   AST_CG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sel |-> (ac < CG_SPAN)); // R9
endmodule

bind chardisp_regcore chardisp_regcore_chk #(.DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .fire(fire), .busy(busy), .accept(accept),
   .sel(sel), .ac(ac), .dr_q(dr_q)
);

// File: tb/tb_chardisp_regcore.sv
module tb_chardisp_regcore;
   localparam int DD_N = 80;
   localparam int CG_N = 64;
   localparam int BUSY = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0, rs_i = 1'b0, rw_i = 1'b0, dir_dec_i = 1'b0;
   logic [7:0] bus_i = 8'h00;
   logic [7:0] bus_o;

   int n_chk = 0;
   int n_bad = 0;

   chardisp_regcore #(.DD_DEPTH(DD_N), .CG_DEPTH(CG_N), .BUSY_CYC(BUSY), .DIR_PORT_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
      .bus_i(bus_i), .dir_dec_i(dir_dec_i), .bus_o(bus_o)
   );

   always #5 clk = ~clk;

   // behavioural reference model
   int m_ac, m_sel, m_dr, m_busy, m_en_prev, m_rs, m_rw, m_dat;
   int m_dd [DD_N];
   int m_cg [CG_N];

   function automatic int m_size();
      return (m_sel != 0) ? CG_N : DD_N;
   endfunction

   function automatic int m_fetch(int sel, int a);
      return (sel != 0) ? m_cg[a] : m_dd[a];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ac = 0; m_sel = 0; m_dr = 0; m_busy = 0; m_en_prev = 0;
         m_rs = 0; m_rw = 0; m_dat = 0;
         foreach (m_dd[i]) m_dd[i] = 0;
         foreach (m_cg[i]) m_cg[i] = 0;
      end else begin
         bit did;
         did = 0;
         if (m_en_prev != 0 && en_i == 1'b0 && m_busy == 0) begin
            if (m_rs == 0 && m_rw == 0) begin
               if (m_dat >= 128) begin
                  m_sel = 0; m_ac = m_dat - 128;
                  if (m_ac >= DD_N) m_ac = m_ac - DD_N;
                  did = 1;
               end else if (m_dat >= 64) begin
                  m_sel = 1; m_ac = m_dat % CG_N; did = 1;
               end
            end else if (m_rs == 1) begin
               if (m_rw == 0) begin
                  if (m_sel != 0) m_cg[m_ac] = m_dat; else m_dd[m_ac] = m_dat;
               end
               if (dir_dec_i) m_ac = (m_ac == 0) ? m_size() - 1 : m_ac - 1;
               else           m_ac = (m_ac + 1) % m_size();
               did = 1;
            end
            if (did) m_dr = m_fetch(m_sel, m_ac);
         end
         if (did) m_busy = BUSY;
         else if (m_busy > 0) m_busy = m_busy - 1;
         if (en_i) begin m_rs = rs_i; m_rw = rw_i; m_dat = bus_i; end
         m_en_prev = en_i;
      end
   end

   function automatic int m_view();
      if (!rw_i) return 0;
      if (rs_i)  return m_dr;
      return ((m_busy > 0) ? 128 : 0) + m_ac;
   endfunction

   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         n_chk++;
         if (int'(bus_o) != m_view()) begin
            n_bad++;
            $display("FAIL %s: bus_o=%02h expected %02h at %0t",
                     (rs_i ? "R4" : "R2"), bus_o, m_view(), $time);
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic peek(input logic rs, input logic rw, output logic [7:0] v);
      rs_i = rs; rw_i = rw;
      #1;
      v = bus_o;
   endtask

   task automatic strobe(input logic rs, input logic rw, input logic [7:0] d, input int gap);
      @(negedge clk);
      rs_i = rs; rw_i = rw; bus_i = d; en_i = 1'b1;
      @(negedge clk);
      en_i = 1'b0; bus_i = 8'hFF;
      @(negedge clk);
      repeat (gap) @(negedge clk);
   endtask

   initial begin
      #2000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      peek(0, 1, v); chk("R1 status", v, 8'h00);
      peek(1, 1, v); chk("R1 data", v, 8'h00);
      peek(0, 0, v); chk("R4 idle", v, 8'h00);
      peek(1, 0, v); chk("R4 write side", v, 8'h00);

      strobe(0, 0, 8'h85, 0);
      peek(0, 1, v); chk("R3 R5 R10 load busy", v, 8'h85);
      repeat (BUSY) @(negedge clk);
      peek(0, 1, v); chk("R10 busy cleared", v, 8'h05);
      peek(1, 1, v); chk("R5 prefetch empty", v, 8'h00);

      strobe(1, 0, 8'h41, BUSY);
      peek(0, 1, v); chk("R6 step", v, 8'h06);
      strobe(1, 0, 8'h42, BUSY);
      strobe(0, 0, 8'h85, BUSY);
      peek(1, 1, v); chk("R5 prefetch", v, 8'h41);
      strobe(1, 1, 8'h00, BUSY);
      peek(1, 1, v); chk("R7 next byte", v, 8'h42);
      peek(0, 1, v); chk("R7 step", v, 8'h06);

      dir_dec_i = 1'b1;
      strobe(0, 0, 8'h86, BUSY);
      strobe(1, 1, 8'h00, BUSY);
      peek(0, 1, v); chk("R8 decrement", v, 8'h05);
      peek(1, 1, v); chk("R8 data", v, 8'h41);
      strobe(0, 0, 8'h80, BUSY);
      strobe(1, 1, 8'h00, BUSY);
      peek(0, 1, v); chk("R9 dd wrap down", v, 8'h4F);
      dir_dec_i = 1'b0;

      strobe(0, 0, 8'hCF, BUSY);
      strobe(1, 0, 8'h55, BUSY);
      peek(0, 1, v); chk("R9 dd wrap up", v, 8'h00);
      strobe(0, 0, 8'hCF, BUSY);
      peek(1, 1, v); chk("R6 stored", v, 8'h55);

      strobe(0, 0, 8'hE4, BUSY);
      peek(0, 1, v); chk("R5 fold", v, 8'h14);

      strobe(0, 0, 8'h7F, BUSY);
      peek(0, 1, v); chk("R5 cg select", v, 8'h3F);
      strobe(1, 0, 8'h1F, BUSY);
      peek(0, 1, v); chk("R9 cg wrap", v, 8'h00);
      strobe(0, 0, 8'h7F, BUSY);
      peek(1, 1, v); chk("R6 cg stored", v, 8'h1F);
      strobe(0, 0, 8'hBF, BUSY);
      peek(1, 1, v); chk("R5 dd separate", v, 8'h00);

      strobe(0, 0, 8'h01, 0);
      peek(0, 1, v); chk("R5 undecoded", v, 8'h3F);

      strobe(0, 0, 8'h8A, 0);
      strobe(1, 0, 8'h77, 0);
      peek(0, 1, v); chk("R10 ignored", v, 8'h8A);
      @(negedge clk);
      peek(0, 1, v); chk("R10 not extended", v, 8'h0A);
      peek(1, 1, v); chk("R10 no write", v, 8'h00);
      repeat (4) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule